// File: doc/BRIEF.md
# Tagged Response Capture Buffer

This block is the response half of a byte-wide host/controller message channel. Every request the controller issues carries an 8-bit sequence tag, shown on `req_tag`. Responses arrive later on a byte-stream port: a tag and a total length on the first beat, one data byte per beat, and a last flag. A response is kept only when its tag equals the live tag. Keeping it advances the tag by one. An abort taken outside the error state also advances the tag, so a response still in flight for the abandoned request is recognised as stale and dropped.

Accepted bytes go into an output buffer of `CAP` bytes. A response longer than the buffer is replaced by a three-byte reply: its first two bytes, followed by a fixed completion code meaning the requested number of bytes cannot be returned. When the last byte is stored, the block sets the length and rewinds the read position to zero. It then raises a one-cycle ready pulse. The downstream transfer machine uses this pulse to enter its read phase, and the first byte is already on `head_byte`. The transfer machine reads the message one byte at a time with `pop`. It can also load a one-byte error status or clear the buffer when it issues a new request.

Top module: `rsp_capture_buffer`

## Requirements
- R1: `req_tag` is 0 after reset. It increases by one (modulo 256) in the cycle after the first beat of an accepted response. It changes at no other time except under R3.
- R2: A response is accepted only when `rsp_tag` on its first beat equals `req_tag` and no abort is taken in that cycle. The beats of a rejected response are consumed up to the one with `rsp_last` and then dropped. They leave the tag, the buffer contents, the length, the position and `rsp_ready` unchanged.
- R3: `abort_req` with `err_state` low advances the tag by one. With `err_state` high it has no effect. An abort in the same cycle as the first beat of a matching response rejects that response, and the tag advances once.
- R4: When `rsp_len` is at most `CAP` (this includes exactly `CAP`), byte k of the response is stored at buffer index k. The length becomes `rsp_len`.
- R5: When `rsp_len` exceeds `CAP`, only bytes 0 and 1 are kept. Index 2 holds `CC` (0xCA by default). The length becomes 3.
- R6: `rsp_ready` is high for exactly the one cycle after the last beat of an accepted response. In that cycle the new length is visible, the position is 0 and `head_byte` is byte 0.
- R7: `head_byte` is the buffer byte at the read position. `drained` is 1, and `head_byte` is 0, when the position is at least the length. `pop` advances the position by one when `drained` is 0. When `drained` is 1, `pop` has no effect.
- R8: `req_issue` sets the length to 0 and the position to 0.
- R9: `err_load` writes `err_code` to index 0, sets the length to 1 and sets the position to 0.
- R10: When several of these fall in one cycle, the first in this list wins: completion of an accepted response, then `err_load`, then `req_issue`, then `pop`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_issue | input | 1 | A request is being issued; clears length and position |
| abort_req | input | 1 | Abort request from the transfer machine |
| err_state | input | 1 | Transfer machine is in its error state |
| err_load | input | 1 | Load a one-byte error status |
| err_code | input | 8 | Error status byte for `err_load` |
| rsp_valid | input | 1 | Response beat valid |
| rsp_last | input | 1 | Final beat of the response |
| rsp_tag | input | 8 | Response tag, sampled on the first beat |
| rsp_len | input | RLEN_W | Total response length, sampled on the first beat |
| rsp_data | input | 8 | Response data byte |
| pop | input | 1 | Advance the read position |
| req_tag | output | 8 | Current sequence tag |
| rsp_ready | output | 1 | One-cycle pulse: a new response is ready |
| buf_len | output | LEN_W | Stored message length |
| head_byte | output | 8 | Byte at the read position |
| drained | output | 1 | Read position has reached the length |

## Verification
The assertions take three things for granted about the inputs. First, every response is at least one beat long. Second, its beat count equals the `rsp_len` given on its first beat. Third, `err_load` never coincides with a captured write to index 0. The stimulus meets these because each frame comes from a single task that derives the beat count from the length it drives. The same task loads error status only when no frame is open. Every cycle is compared against a behavioural model. That model also computes the tag filtering and the oversize substitution from the requirements.

// File: rtl/rsp_cap_pkg.sv
package rsp_cap_pkg;

  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_TAKE = 2'd1,
    CAP_DROP = 2'd2
  } cap_state_e;

  // bytes of an oversized response that survive before the code byte
  localparam int unsigned KEPT_ON_OVERFLOW = 2;

  function automatic logic over_capacity(input int unsigned frame_len,
                                         input int unsigned cap);
    return frame_len > cap;
  endfunction

  function automatic logic keep_beat(input int unsigned idx,
                                     input logic        ovs,
                                     input int unsigned cap);
    if (ovs) return idx < KEPT_ON_OVERFLOW;
    return idx < cap;
  endfunction

  function automatic int unsigned stored_len(input int unsigned frame_len,
                                             input int unsigned cap);
    if (frame_len > cap) return KEPT_ON_OVERFLOW + 1;
    return frame_len;
  endfunction

endpackage

// File: rtl/rsp_tag_ctr.sv
module rsp_tag_ctr #(
  parameter int unsigned TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump_accept,
  input  logic             bump_abort,
  output logic [TAG_W-1:0] tag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag <= '0;
    end else if (bump_accept || bump_abort) begin
      tag <= tag + 1'b1;
    end
  end

endmodule

// File: rtl/rsp_frame_cap.sv
module rsp_frame_cap
  import rsp_cap_pkg::*;
#(
  parameter int unsigned TAG_W  = 8,
  parameter int unsigned CAP    = 64,
  parameter int unsigned RLEN_W = 10,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned LEN_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TAG_W-1:0]  cur_tag,
  input  logic              abort_take,
  input  logic              rsp_valid,
  input  logic              rsp_last,
  input  logic [TAG_W-1:0]  rsp_tag,
  input  logic [RLEN_W-1:0] rsp_len,
  input  logic [7:0]        rsp_data,
  output logic              accept,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [7:0]        wr_data,
  output logic              cc_en,
  output logic              commit,
  output logic [LEN_W-1:0]  commit_len,
  output logic              drop_beat
);

  cap_state_e        state_q;
  logic [RLEN_W-1:0] idx_q;
  logic [RLEN_W-1:0] len_q;
  logic              ovs_q;

  logic              first_beat;
  logic              hit;
  logic [RLEN_W-1:0] cur_idx;
  logic [RLEN_W-1:0] cur_len;
  logic              cur_ovs;
  logic              take_beat;

  always_comb begin
    first_beat = rsp_valid && (state_q == CAP_IDLE);
    hit        = first_beat && (rsp_tag == cur_tag) && !abort_take;
    cur_idx    = (state_q == CAP_IDLE) ? '0 : idx_q;
    cur_len    = (state_q == CAP_IDLE) ? rsp_len : len_q;
    cur_ovs    = (state_q == CAP_IDLE) ? over_capacity(32'(rsp_len), CAP) : ovs_q;
    take_beat  = hit || (rsp_valid && (state_q == CAP_TAKE));
  end

  assign accept     = hit;
  assign wr_en      = take_beat && keep_beat(32'(cur_idx), cur_ovs, CAP);
  assign wr_idx     = cur_idx[IDX_W-1:0];
  assign wr_data    = rsp_data;
  assign commit     = take_beat && rsp_last;
  assign cc_en      = commit && cur_ovs;
  assign commit_len = LEN_W'(stored_len(32'(cur_len), CAP));
  assign drop_beat  = rsp_valid && ((first_beat && !hit) || (state_q == CAP_DROP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CAP_IDLE;
      idx_q   <= '0;
      len_q   <= '0;
      ovs_q   <= 1'b0;
    end else begin
      case (state_q)
        CAP_IDLE: begin
          if (first_beat && !rsp_last) begin
            if (hit) begin
              state_q <= CAP_TAKE;
              idx_q   <= RLEN_W'(1);
              len_q   <= rsp_len;
              ovs_q   <= cur_ovs;
            end else begin
              state_q <= CAP_DROP;
            end
          end
        end
        CAP_TAKE: begin
          if (rsp_valid) begin
            idx_q <= idx_q + 1'b1;
            if (rsp_last) state_q <= CAP_IDLE;
          end
        end
        CAP_DROP: begin
          if (rsp_valid && rsp_last) state_q <= CAP_IDLE;
        end
        default: state_q <= CAP_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rsp_buf_store.sv
module rsp_buf_store #(
  parameter int unsigned CAP   = 64,
  parameter logic [7:0]  CC    = 8'hCA,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic             cc_en,
  input  logic             commit,
  input  logic [LEN_W-1:0] commit_len,
  input  logic             err_load,
  input  logic [7:0]       err_code,
  input  logic             req_issue,
  input  logic             pop,
  output logic [LEN_W-1:0] buf_len,
  output logic [LEN_W-1:0] head_pos,
  output logic [7:0]       head_byte,
  output logic             drained
);

  logic [CAP-1:0][7:0] cells;
  logic [LEN_W-1:0]    len_q;
  logic [LEN_W-1:0]    pos_q;

  for (genvar e = 0; e < CAP; e++) begin : g_entry
    logic [7:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(e))) begin
        cell_q <= wr_data;
      end else if (cc_en && (e == 2)) begin
        cell_q <= CC;
      end else if (err_load && !commit && (e == 0)) begin
        cell_q <= err_code;
      end
    end
    assign cells[e] = cell_q;
  end

  assign drained   = (pos_q >= len_q);
  assign head_byte = drained ? 8'h00 : cells[pos_q[IDX_W-1:0]];
  assign buf_len   = len_q;
  assign head_pos  = pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      pos_q <= '0;
    end else if (commit) begin
      len_q <= commit_len;
      pos_q <= '0;
    end else if (err_load) begin
      len_q <= LEN_W'(1);
      pos_q <= '0;
    end else if (req_issue) begin
      len_q <= '0;
      pos_q <= '0;
    end else if (pop && !drained) begin
      pos_q <= pos_q + 1'b1;
    end
  end

endmodule

// File: rtl/rsp_capture_buffer.sv
module rsp_capture_buffer #(
  parameter int unsigned TAG_W  = 8,
  parameter int unsigned CAP    = 64,
  parameter logic [7:0]  CC     = 8'hCA,
  parameter int unsigned RLEN_W = 10,
  localparam int unsigned IDX_W = $clog2(CAP),
  localparam int unsigned LEN_W = $clog2(CAP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_issue,
  input  logic              abort_req,
  input  logic              err_state,
  input  logic              err_load,
  input  logic [7:0]        err_code,
  input  logic              rsp_valid,
  input  logic              rsp_last,
  input  logic [TAG_W-1:0]  rsp_tag,
  input  logic [RLEN_W-1:0] rsp_len,
  input  logic [7:0]        rsp_data,
  input  logic              pop,
  output logic [TAG_W-1:0]  req_tag,
  output logic              rsp_ready,
  output logic [LEN_W-1:0]  buf_len,
  output logic [7:0]        head_byte,
  output logic              drained
);

  logic             abort_take;
  logic             accept;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;
  logic             cc_en;
  logic             commit;
  logic [LEN_W-1:0] commit_len;
  logic             drop_beat;
  logic [LEN_W-1:0] head_pos;

  assign abort_take = abort_req && !err_state;

  rsp_tag_ctr #(.TAG_W(TAG_W)) u_tag (
    .clk         (clk),
    .rst_n       (rst_n),
    .bump_accept (accept),
    .bump_abort  (abort_take),
    .tag         (req_tag)
  );

  rsp_frame_cap #(
    .TAG_W (TAG_W),
    .CAP   (CAP),
    .RLEN_W(RLEN_W),
    .IDX_W (IDX_W),
    .LEN_W (LEN_W)
  ) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur_tag    (req_tag),
    .abort_take (abort_take),
    .rsp_valid  (rsp_valid),
    .rsp_last   (rsp_last),
    .rsp_tag    (rsp_tag),
    .rsp_len    (rsp_len),
    .rsp_data   (rsp_data),
    .accept     (accept),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .cc_en      (cc_en),
    .commit     (commit),
    .commit_len (commit_len),
    .drop_beat  (drop_beat)
  );

  rsp_buf_store #(
    .CAP  (CAP),
    .CC   (CC),
    .IDX_W(IDX_W),
    .LEN_W(LEN_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .cc_en      (cc_en),
    .commit     (commit),
    .commit_len (commit_len),
    .err_load   (err_load),
    .err_code   (err_code),
    .req_issue  (req_issue),
    .pop        (pop),
    .buf_len    (buf_len),
    .head_pos   (head_pos),
    .head_byte  (head_byte),
    .drained    (drained)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_ready <= 1'b0;
    else        rsp_ready <= commit;
  end

endmodule

// File: rtl/rsp_capture_chk.sv
module rsp_capture_chk #(
  parameter int unsigned TAG_W = 8,
  parameter int unsigned CAP   = 64,
  parameter int unsigned LEN_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TAG_W-1:0] req_tag,
  input logic             accept,
  input logic             abort_take,
  input logic             commit,
  input logic             cc_en,
  input logic             wr_en,
  input logic             drop_beat,
  input logic             rsp_ready,
  input logic [LEN_W-1:0] buf_len,
  input logic [LEN_W-1:0] head_pos,
  input logic             drained,
  input logic             req_issue,
  input logic             err_load,
  input logic             pop
);

  assert_tag_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept || abort_take) |=> $stable(req_tag));

  assert_tag_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> req_tag == TAG_W'($past(req_tag) + 1'b1));

  assert_drop_nowrite_R2: assert property (@(posedge clk) disable iff (!rst_n)
    drop_beat |-> !wr_en && !accept);

  assert_abort_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    abort_take |=> req_tag == TAG_W'($past(req_tag) + 1'b1));

  assert_len_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_len <= LEN_W'(CAP));

  assert_ovs_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cc_en |=> buf_len == LEN_W'(3));

  assert_ready_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> rsp_ready && head_pos == '0);

  assert_pop_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !drained && !commit && !err_load && !req_issue)
      |=> head_pos == LEN_W'($past(head_pos) + 1'b1));

  assert_issue_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_issue && !commit && !err_load) |=> buf_len == '0 && head_pos == '0);

  assert_errload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_load && !commit) |=> buf_len == LEN_W'(1) && head_pos == '0);

endmodule

bind rsp_capture_buffer rsp_capture_chk #(
  .TAG_W(TAG_W),
  .CAP  (CAP),
  .LEN_W(LEN_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_tag    (req_tag),
  .accept     (accept),
  .abort_take (abort_take),
  .commit     (commit),
  .cc_en      (cc_en),
  .wr_en      (wr_en),
  .drop_beat  (drop_beat),
  .rsp_ready  (rsp_ready),
  .buf_len    (buf_len),
  .head_pos   (head_pos),
  .drained    (drained),
  .req_issue  (req_issue),
  .err_load   (err_load),
  .pop        (pop)
);

// File: tb/rsp_capture_buffer_tb.sv
module rsp_capture_buffer_tb;

  localparam int CAP = 64;
  localparam int CCV = 8'hCA;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_issue = 0, abort_req = 0, err_state = 0, err_load = 0;
  logic [7:0] err_code = 0;
  logic       rsp_valid = 0, rsp_last = 0;
  logic [7:0] rsp_tag = 0;
  logic [9:0] rsp_len = 0;
  logic [7:0] rsp_data = 0;
  logic       pop = 0;
  logic [7:0] req_tag;
  logic       rsp_ready;
  logic [6:0] buf_len;
  logic [7:0] head_byte;
  logic       drained;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  rsp_capture_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .req_issue(req_issue), .abort_req(abort_req),
    .err_state(err_state), .err_load(err_load), .err_code(err_code),
    .rsp_valid(rsp_valid), .rsp_last(rsp_last), .rsp_tag(rsp_tag),
    .rsp_len(rsp_len), .rsp_data(rsp_data), .pop(pop), .req_tag(req_tag),
    .rsp_ready(rsp_ready), .buf_len(buf_len), .head_byte(head_byte),
    .drained(drained)
  );

  // behavioural reference model
  int m_tag, m_len, m_pos, m_st, m_idx, m_flen, m_rdy;
  bit m_ovs;
  int m_mem[CAP];

  task automatic store_beat();
    if (m_ovs ? (m_idx < 2) : (m_idx < CAP)) m_mem[m_idx] = int'(rsp_data);
    m_idx++;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tag = 0; m_len = 0; m_pos = 0; m_st = 0; m_idx = 0; m_flen = 0;
      m_rdy = 0; m_ovs = 0;
      foreach (m_mem[i]) m_mem[i] = 0;
    end else begin
      bit ab;
      bit com;
      ab  = abort_req && !err_state;
      com = 0;
      if (rsp_valid) begin
        if (m_st == 0) begin
          if (int'(rsp_tag) == m_tag && !ab) begin
            m_tag  = (m_tag + 1) % 256;
            m_flen = int'(rsp_len);
            m_ovs  = int'(rsp_len) > CAP;
            m_idx  = 0;
            store_beat();
            if (rsp_last) com = 1; else m_st = 1;
          end else if (!rsp_last) begin
            m_st = 2;
          end
        end else if (m_st == 1) begin
          store_beat();
          if (rsp_last) begin com = 1; m_st = 0; end
        end else if (rsp_last) begin
          m_st = 0;
        end
      end
      if (ab) m_tag = (m_tag + 1) % 256;
      if (com) begin
        if (m_ovs) m_mem[2] = CCV;
        m_len = m_ovs ? 3 : m_flen;
        m_pos = 0;
      end else if (err_load) begin
        m_mem[0] = int'(err_code); m_len = 1; m_pos = 0;
      end else if (req_issue) begin
        m_len = 0; m_pos = 0;
      end else if (pop && m_pos < m_len) begin
        m_pos++;
      end
      m_rdy = com;
    end
  end

  task automatic chk(input string rq, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", rq, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      int hb;
      hb = (m_pos >= m_len) ? 0 : m_mem[m_pos];
      chk("R1", "model tag", int'(req_tag), m_tag);
      chk("R4", "model length", int'(buf_len), m_len);
      chk("R7", "model head", int'(head_byte), hb);
      chk("R7", "model drained", int'(drained), int'(m_pos >= m_len));
      chk("R6", "model ready", int'(rsp_ready), m_rdy);
    end
  end

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic pulse_pop(input int n);
    for (int i = 0; i < n; i++) begin
      pop = 1; tick(); pop = 0;
    end
  endtask

  task automatic send_rsp(input int tg, input int ln, input int base,
                          input bit abort_first, input bit req_on_last);
    for (int i = 0; i < ln; i++) begin
      rsp_valid = 1;
      rsp_tag   = 8'(tg);
      rsp_len   = 10'(ln);
      rsp_data  = 8'(base + i);
      rsp_last  = (i == ln - 1);
      abort_req = abort_first && (i == 0);
      req_issue = req_on_last && (i == ln - 1);
      tick();
    end
    rsp_valid = 0; rsp_last = 0; abort_req = 0; req_issue = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1", "reset tag", int'(req_tag), 0);
    chk("R4", "reset length", int'(buf_len), 0);
    chk("R7", "reset drained", int'(drained), 1);
    chk("R6", "reset ready", int'(rsp_ready), 0);

    // normal response
    req_issue = 1; tick(); req_issue = 0;
    chk("R8", "length after issue", int'(buf_len), 0);
    send_rsp(0, 4, 8'h10, 0, 0);
    chk("R6", "ready after last beat", int'(rsp_ready), 1);
    chk("R6", "first byte presented", int'(head_byte), 8'h10);
    chk("R4", "stored length", int'(buf_len), 4);
    chk("R1", "tag after accept", int'(req_tag), 1);
    tick();
    chk("R6", "ready is one cycle", int'(rsp_ready), 0);
    pulse_pop(1);
    chk("R7", "second byte", int'(head_byte), 8'h11);
    pulse_pop(3);
    chk("R7", "drained after all", int'(drained), 1);
    pulse_pop(2);
    chk("R7", "pop when drained", int'(buf_len), 4);

    // stale tag rejected
    err_code = 8'h55; err_load = 1; tick(); err_load = 0;
    send_rsp(5, 3, 8'h40, 0, 0);
    chk("R2", "no ready on mismatch", int'(rsp_ready), 0);
    chk("R2", "buffer untouched", int'(head_byte), 8'h55);
    chk("R2", "length untouched", int'(buf_len), 1);
    chk("R2", "tag unchanged", int'(req_tag), 1);

    // aborts
    abort_req = 1; err_state = 1; tick(); abort_req = 0; err_state = 0;
    chk("R3", "abort in error state", int'(req_tag), 1);
    abort_req = 1; tick(); abort_req = 0;
    chk("R3", "abort bumps tag", int'(req_tag), 2);
    send_rsp(1, 2, 8'h20, 0, 0);
    chk("R3", "late response dropped", int'(head_byte), 8'h55);

    // oversized response
    send_rsp(2, 70, 8'h80, 0, 0);
    chk("R5", "oversize length", int'(buf_len), 3);
    chk("R5", "oversize byte0", int'(head_byte), 8'h80);
    pulse_pop(1);
    chk("R5", "oversize byte1", int'(head_byte), 8'h81);
    pulse_pop(1);
    chk("R5", "completion code", int'(head_byte), CCV);

    // exactly full
    send_rsp(3, CAP, 8'h00, 0, 0);
    chk("R4", "full length", int'(buf_len), CAP);
    pulse_pop(CAP - 1);
    chk("R4", "last full byte", int'(head_byte), CAP - 1);

    // error status load
    err_code = 8'h02; err_load = 1; tick(); err_load = 0;
    chk("R9", "error length", int'(buf_len), 1);
    chk("R9", "error byte", int'(head_byte), 8'h02);

    // abort on first beat of a matching response
    send_rsp(4, 2, 8'h90, 1, 0);
    chk("R3", "abort rejects frame", int'(head_byte), 8'h02);
    chk("R3", "single tag step", int'(req_tag), 5);

    // issue and pop together
    req_issue = 1; pop = 1; tick(); req_issue = 0; pop = 0;
    chk("R10", "issue beats pop", int'(buf_len), 0);

    // completion and issue together
    send_rsp(5, 1, 8'h77, 0, 1);
    chk("R10", "completion beats issue len", int'(buf_len), 1);
    chk("R10", "completion beats issue byte", int'(head_byte), 8'h77);

    // back-to-back single-beat frames
    send_rsp(6, 1, 8'hA1, 0, 0);
    send_rsp(7, 1, 8'hA2, 0, 0);
    chk("R6", "back-to-back ready", int'(rsp_ready), 1);
    chk("R1", "back-to-back tag", int'(req_tag), 8);

    repeat (3) tick();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule